// File: doc/BRIEF.md
# Two-Context Time-Shared Update Datapath

This block stands in for two copies of a small sequential unit whose state advances by one add-and-rotate step per slow clock. Instead of building the next-state arithmetic twice, it keeps a single combinational update core. It holds two separate state registers, one per context, and runs on a clock at twice the per-context rate. An internal select flip-flop alternates between the contexts on every fast edge. The selected context's state and input word go through the shared core, and only that context's register takes the result.

Each context therefore advances once every two fast cycles. That is the same throughput it would have as a standalone unit on the slow clock, while the adder and rotator exist only once. Each context has its own output word, which holds steady between its updates. It also has a one-cycle valid pulse that marks a fresh value.

Top module: `dual_ctx_core`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become zero and both valid flags become low. The first edge with `rst` low updates context 0.
- R2: On an update of context k, its output becomes `rotate_left((old + din_k) mod 2^WIDTH, ROT)`. Any carry out of the sum is discarded. With the defaults WIDTH=16 and ROT=1, bit 15 of the sum moves to bit 0.
- R3: After reset, updates alternate strictly between the two contexts on consecutive fast edges: context 0, context 1, context 0, and so on.
- R4: A context's input word is sampled only on the edge that updates that context. A value on the other context's input at that edge has no effect on any output.
- R5: On an edge that updates one context, the other context's output keeps its value.
- R6: `ctxK_vld` is high for exactly the one fast cycle after context K's register updates. The two valid flags are never high together.
- R7: Outside reset, each context's valid flag pulses every second fast cycle, giving one update per two fast cycles for each context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the per-context update rate |
| rst | input | 1 | Synchronous reset, active high |
| ctx0_din | input | WIDTH | Input word of context 0 |
| ctx1_din | input | WIDTH | Input word of context 1 |
| ctx0_dout | output | WIDTH | Current state of context 0 |
| ctx1_dout | output | WIDTH | Current state of context 1 |
| ctx0_vld | output | 1 | One-cycle pulse after context 0 updates |
| ctx1_vld | output | 1 | One-cycle pulse after context 1 updates |

## Verification
The bench builds the block with WIDTH=16 and ROT=1. At this width, hand-chosen vectors can drive the sum past 2^16 to drop the carry and push a set top bit around into bit 0. Random words over the full 16-bit range reach every bit of the rotator. Throughout, each input changes on every fast cycle, including while its context is idle, so any leak of the unselected input or any write to the idle register shows up as a mismatch. A mid-run reset shows that the alternation restarts with context 0.

// File: rtl/dual_ctx_pkg.sv
package dual_ctx_pkg;

    localparam int NUM_CTX = 2;

    typedef enum logic {
        CTX0 = 1'b0,
        CTX1 = 1'b1
    } ctx_id_e;

endpackage

// File: rtl/dc_select_seq.sv
module dc_select_seq
    import dual_ctx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output ctx_id_e            sel_q,
    output logic [NUM_CTX-1:0] wr_en
);

    typedef struct packed {
        ctx_id_e sel;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.sel = CTX0;
        end else begin
            st_d.sel = (st_q.sel == CTX0) ? CTX1 : CTX0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_q = st_q.sel;

    always_comb begin
        wr_en = '0;
        if (!rst) begin
            wr_en[0] = (st_q.sel == CTX0);
            wr_en[1] = (st_q.sel == CTX1);
        end
    end

    // R3: the select changes on every edge outside reset
    assert_sel_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sel_q != $past(sel_q)));

    // R6: never more than one context written per edge
    assert_one_writer_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

endmodule

// File: rtl/dc_shared_update.sv
module dc_shared_update #(
    parameter int WIDTH = 16,
    parameter int ROT   = 1
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] next_o
);

    localparam int BACK = WIDTH - ROT;

    logic [WIDTH-1:0] sum_w;

    always_comb begin
        sum_w  = state_i + data_i;
        next_o = (sum_w << ROT) | (sum_w >> BACK);
    end

    initial begin
        assert_rot_range_R2: assert (ROT > 0 && ROT < WIDTH);
    end

endmodule

// File: rtl/dc_ctx_bank.sv
module dc_ctx_bank
    import dual_ctx_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CTX-1:0]              wr_en,
    input  logic [WIDTH-1:0]                next_i,
    output logic [NUM_CTX-1:0][WIDTH-1:0]   state_o,
    output logic [NUM_CTX-1:0]              valid_o
);

    typedef struct packed {
        logic [NUM_CTX-1:0][WIDTH-1:0] state;
        logic [NUM_CTX-1:0]            valid;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int k = 0; k < NUM_CTX; k++) begin
            bank_d.valid[k] = 1'b0;
            if (rst) begin
                bank_d.state[k] = '0;
            end else if (wr_en[k]) begin
                bank_d.state[k] = next_i;
                bank_d.valid[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign state_o = bank_q.state;
    assign valid_o = bank_q.valid;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx_chk
        // R5: an idle context keeps its register
        assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
            !wr_en[g] |=> $stable(state_o[g]));
        // R6: a write is flagged in the following cycle
        assert_valid_after_write_R6: assert property (@(posedge clk) disable iff (rst)
            wr_en[g] |=> valid_o[g]);
    end

endmodule

// File: rtl/dual_ctx_core.sv
module dual_ctx_core
    import dual_ctx_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int ROT   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] ctx0_din,
    input  logic [WIDTH-1:0] ctx1_din,
    output logic [WIDTH-1:0] ctx0_dout,
    output logic [WIDTH-1:0] ctx1_dout,
    output logic             ctx0_vld,
    output logic             ctx1_vld
);

    ctx_id_e                        sel_q;
    logic [NUM_CTX-1:0]             wr_en;
    logic [NUM_CTX-1:0][WIDTH-1:0]  state_w;
    logic [NUM_CTX-1:0]             valid_w;
    logic [WIDTH-1:0]               mux_state;
    logic [WIDTH-1:0]               mux_data;
    logic [WIDTH-1:0]               next_w;

    dc_select_seq u_sel (
        .clk   (clk),
        .rst   (rst),
        .sel_q (sel_q),
        .wr_en (wr_en)
    );

    always_comb begin
        if (sel_q == CTX1) begin
            mux_state = state_w[1];
            mux_data  = ctx1_din;
        end else begin
            mux_state = state_w[0];
            mux_data  = ctx0_din;
        end
    end

    dc_shared_update #(
        .WIDTH (WIDTH),
        .ROT   (ROT)
    ) u_core (
        .state_i (mux_state),
        .data_i  (mux_data),
        .next_o  (next_w)
    );

    dc_ctx_bank #(
        .WIDTH (WIDTH)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .next_i  (next_w),
        .state_o (state_w),
        .valid_o (valid_w)
    );

    assign ctx0_dout = state_w[0];
    assign ctx1_dout = state_w[1];
    assign ctx0_vld  = valid_w[0];
    assign ctx1_vld  = valid_w[1];

    // R6: the two valid flags are exclusive
    assert_vld_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctx1_vld, ctx0_vld}));

    // R7: a context's pulse is followed by the other context's pulse
    assert_pace_ctx0_R7: assert property (@(posedge clk) disable iff (rst)
        ctx0_vld |=> (!ctx0_vld && ctx1_vld));
    assert_pace_ctx1_R7: assert property (@(posedge clk) disable iff (rst)
        ctx1_vld |=> (!ctx1_vld && ctx0_vld));

    // R1: reset clears both contexts and their flags
    assert_reset_clear_R1: assert property (@(posedge clk)
        disable iff (!rst)
        rst |=> (ctx0_dout == '0 && ctx1_dout == '0 && !ctx0_vld && !ctx1_vld));

endmodule

// File: tb/dual_ctx_core_bench.sv
`timescale 1ns/1ps
module dual_ctx_core_bench;

    localparam int W = 16;

    typedef struct packed {
        logic [W-1:0] in0;
        logic [W-1:0] in1;
        logic [W-1:0] exp0;
        logic [W-1:0] exp1;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0001, 16'hFFFF, 16'h0002, 16'h0000},
        '{16'h1234, 16'h8000, 16'h0002, 16'h0001},
        '{16'h7FFE, 16'hAAAA, 16'h0001, 16'h0001},
        '{16'h5555, 16'hFFFF, 16'h0001, 16'h0000},
        '{16'h4000, 16'h0000, 16'h8002, 16'h0000},
        '{16'h0000, 16'hC000, 16'h8002, 16'h8001},
        '{16'h7FFE, 16'h1111, 16'h0000, 16'h8001},
        '{16'h2222, 16'h0001, 16'h0000, 16'h0005}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din0 = '0, din1 = '0;
    logic [W-1:0] dout0, dout1;
    logic         vld0, vld1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [W-1:0] model0, model1;
    bit           turn;

    always #10 clk = ~clk;

    dual_ctx_core #(.WIDTH(W), .ROT(1)) u_dual_ctx_core (
        .clk       (clk),
        .rst       (rst),
        .ctx0_din  (din0),
        .ctx1_din  (din1),
        .ctx0_dout (dout0),
        .ctx1_dout (dout1),
        .ctx0_vld  (vld0),
        .ctx1_vld  (vld1)
    );

    function automatic logic [W-1:0] advance(input logic [W-1:0] s, input logic [W-1:0] x);
        logic [W:0] wide;
        wide = {1'b0, s} + {1'b0, x};
        return {wide[W-2:0], wide[W-1]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // one fast cycle: drive both inputs, let the edge pass, check at negedge
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b);
        din0 = a;
        din1 = b;
        if (!turn) model0 = advance(model0, a);
        else       model1 = advance(model1, b);
        @(posedge clk);
        @(negedge clk);
        if (!turn) begin
            check("R2 ctx0 update", dout0, model0);
            check("R5 ctx1 hold", dout1, model1);
        end else begin
            check("R2 ctx1 update", dout1, model1);
            check("R5 ctx0 hold", dout0, model0);
        end
        check("R6 R3 ctx0 valid", vld0, !turn);
        check("R7 R3 ctx1 valid", vld1, turn);
        turn = !turn;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din0 = 16'hFFFF;
        din1 = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset dout0", dout0, 0);
        check("R1 reset dout1", dout1, 0);
        check("R1 reset vld0", vld0, 0);
        check("R1 reset vld1", vld1, 0);
        @(posedge clk);
        @(negedge clk);
        check("R1 reset held dout0", dout0, 0);
        check("R1 reset held vld1", vld1, 0);
        rst = 1'b0;
        model0 = '0;
        model1 = '0;
        turn = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();

        // table walk: fixed vectors with hand-computed results (R2, R4 carry and wrap)
        foreach (VECS[i]) begin
            step(VECS[i].in0, VECS[i].in1);
            check("R4 table ctx0", dout0, VECS[i].exp0);
            check("R4 table ctx1", dout1, VECS[i].exp1);
        end

        // R1: reset in mid-run, then the first update must hit context 0
        do_reset();
        step(16'h0003, 16'h7777);
        check("R1 first update ctx0", dout0, 16'h0006);
        check("R1 ctx1 untouched", dout1, 16'h0000);
        check("R1 first valid ctx0", vld0, 1);

        // R4: an idle input swinging wildly changes nothing
        step(16'hDEAD, 16'h0010);
        check("R4 ctx0 ignores idle input", dout0, 16'h0006);
        step(16'h0000, 16'hBEEF);
        check("R4 ctx1 ignores idle input", dout1, 16'h0020);

        // R2 R7: long random run, each context gets over 1000 updates
        for (int n = 0; n < 2400; n++) begin
            step(W'($urandom), W'($urandom));
        end

        finish_run();
    end

endmodule